// File: doc/BRIEF.md
# Scan-Driven Flash Erase Controller

This block is a two-bit test data register, reached through a JTAG TAP, that launches and tracks erase operations on an on-chip flash. When the TAP captures into it, the chain picks up the current Busy and Error flags, so a debugger can poll progress. When the TAP updates it, the first bit shifted in acts as a write-only Start command. An erase is launched only if Start is set, at least one of the separately programmed erase-type bits (page, sector, mass) is set, and no erase is already in progress.

On launch the block issues a one-cycle request to the flash. The request carries the selected erase kind and a target: the flash address for a page erase, or the block identifier for a sector erase. Busy stays high until the flash reports completion. At that point Error takes the flash's failure indication. Busy and Error also drive a processor-side status pair, so firmware sees the same state as the scan chain. The TAP state machine and the flash's internal erase timing are outside this block. The TAP strobes are taken as one-cycle pulses in the block's clock domain.

Top module: `flash_erase_tdr`

## Requirements
- R1: After reset, Busy, Error, the erase request, both status outputs and `tdo` are all 0.
- R2: A cycle with `capture_dr` high loads the chain so that `tdo` shows Busy on the next cycle, and Error after one further shift.
- R3: Each cycle with `shift_dr` high moves `tdi` into bit 1 and bit 1 into bit 0, where bit 0 drives `tdo`. The chain is exactly two bits long, so a bit shifted in reaches `tdo` after two shifts.
- R4: An `update_dr` cycle launches an erase when chain bit 0 (Start) is 1, `erase_mode` is non-zero and Busy is 0. One cycle later `erase_req` is high for exactly one cycle, Busy is 1 and Error is 0.
- R5: An `update_dr` with Start = 0, or with `erase_mode` = 0, launches nothing and leaves Busy and Error unchanged.
- R6: `erase_mode` bit 0 selects page, bit 1 sector and bit 2 mass. When several bits are set, the priority is mass, then sector, then page. `erase_kind` reports page = 1, sector = 2 and mass = 3.
- R7: The `erase_target` is `flash_addr` for a page erase, `block_id` zero-extended for a sector erase, and 0 for a mass erase. Kind and target are held until the next launch.
- R8: A Start received while Busy is 1 is ignored. No request is issued, and kind and target are unchanged.
- R9: `flash_done` while Busy clears Busy on the next cycle and sets Error to the value of `flash_fail` in that same cycle.
- R10: `stat_busy` and `stat_err` always equal the Busy and Error flags that the scan chain captures.
- R11: `flash_done` while Busy is 0 has no effect on Busy or Error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (TCK domain) |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_dr | input | 1 | TAP capture strobe for this register |
| shift_dr | input | 1 | TAP shift enable for this register |
| update_dr | input | 1 | TAP update strobe for this register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| erase_mode | input | 3 | Erase-type bits: 0 page, 1 sector, 2 mass |
| flash_addr | input | ADDR_W | Address used by page erase |
| block_id | input | BLK_W | Block identifier used by sector erase |
| erase_req | output | 1 | One-cycle erase request to the flash |
| erase_kind | output | 2 | Kind of the latest erase: 1 page, 2 sector, 3 mass |
| erase_target | output | ADDR_W | Region selector of the latest erase |
| flash_done | input | 1 | Flash reports the erase finished |
| flash_fail | input | 1 | Flash reports the erase failed (valid with done) |
| stat_busy | output | 1 | Processor-visible busy mirror |
| stat_err | output | 1 | Processor-visible error mirror |

## Verification
Every result is one register away from the edge that causes it. The captured Busy is on `tdo` in the cycle after the capture strobe, and the Error bit follows one shift later. Request, Busy, kind and target appear in the cycle after the update strobe, and the request drops again in the cycle after that. Busy and Error change in the cycle after `flash_done`. The bench drives inputs on falling edges and samples on the falling edge that follows each causing rising edge. It sweeps every Start value, every erase-mode code and both completion outcomes from idle, and inside each busy window it issues a second Start and an early completion to check that both are handled as R8 and R9 require.

// File: rtl/flash_erase_pkg.sv
// Shared types for the scan-driven flash erase controller.
// Assumes three erase-type bits: page, sector and mass.
package flash_erase_pkg;
    localparam int MODE_W = 3;
    localparam int MODE_PAGE = 0;
    localparam int MODE_SECTOR = 1;
    localparam int MODE_MASS = 2;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_PAGE   = 2'd1,
        KIND_SECTOR = 2'd2,
        KIND_MASS   = 2'd3
    } erase_kind_t;
endpackage

// File: rtl/erase_scan_chain.sv
// Two-bit test data register. Capture loads {error, busy}, shift moves
// TDI toward bit 0, and bit 0 drives TDO. Assumes the TAP strobes are
// mutually exclusive one-cycle pulses in this clock domain.
module erase_scan_chain #(
    parameter int CHAIN_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               tdi,
    input  logic               busy,
    input  logic               err,
    output logic               tdo,
    output logic [CHAIN_W-1:0] chain
);
    logic [CHAIN_W-1:0] sr_q;

    // Capture status, shift serial data, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (capture_dr) begin
            sr_q <= {{(CHAIN_W-2){1'b0}}, err, busy};
        end else if (shift_dr) begin
            sr_q <= {tdi, sr_q[CHAIN_W-1:1]};
        end
    end

    assign tdo   = sr_q[0];
    assign chain = sr_q;
endmodule

// File: rtl/erase_launch.sv
// Start qualification and erase-type priority. Purely combinational:
// it decides whether an update launches an erase and what kind/target.
// Assumes the caller registers the result.
module erase_launch
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 4
) (
    input  logic              update_dr,
    input  logic              start_bit,
    input  logic              busy,
    input  logic [MODE_W-1:0] erase_mode,
    input  logic [ADDR_W-1:0] flash_addr,
    input  logic [BLK_W-1:0]  block_id,
    output logic              launch,
    output erase_kind_t       kind,
    output logic [ADDR_W-1:0] target
);
    // Pick the highest-priority requested kind and its region selector.
    always_comb begin
        kind   = KIND_NONE;
        target = '0;
        if (erase_mode[MODE_MASS]) begin
            kind   = KIND_MASS;
            target = '0;
        end else if (erase_mode[MODE_SECTOR]) begin
            kind   = KIND_SECTOR;
            target = ADDR_W'(block_id);
        end else if (erase_mode[MODE_PAGE]) begin
            kind   = KIND_PAGE;
            target = flash_addr;
        end
    end

    // Launch only on an update with Start set, a kind chosen, and no erase running.
    assign launch = update_dr && start_bit && (kind != KIND_NONE) && !busy;
endmodule

// File: rtl/erase_status.sv
// Busy/Error tracking plus the latched request. Busy rises on launch
// and falls on flash completion; Error clears on launch and takes the
// failure flag on completion. Assumes launch is never asserted while busy.
module erase_status
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  erase_kind_t       kind_in,
    input  logic [ADDR_W-1:0] target_in,
    input  logic              flash_done,
    input  logic              flash_fail,
    output logic              busy,
    output logic              err,
    output logic              req,
    output erase_kind_t       kind,
    output logic [ADDR_W-1:0] target
);
    // Busy and Error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            err  <= 1'b0;
        end else if (launch) begin
            busy <= 1'b1;
            err  <= 1'b0;
        end else if (busy && flash_done) begin
            busy <= 1'b0;
            err  <= flash_fail;
        end
    end

    // One-cycle request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= launch;
    end

    // Hold kind and target from the latest launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind   <= KIND_NONE;
            target <= '0;
        end else if (launch) begin
            kind   <= kind_in;
            target <= target_in;
        end
    end
endmodule

// File: rtl/flash_erase_tdr.sv
// Top of the scan-driven flash erase controller: chain, launch logic
// and status tracking. Status outputs mirror the chain's Busy/Error.
// Assumes TAP strobes already decoded for this register's instruction.
module flash_erase_tdr
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic [2:0]        erase_mode,
    input  logic [ADDR_W-1:0] flash_addr,
    input  logic [BLK_W-1:0]  block_id,
    output logic              erase_req,
    output logic [1:0]        erase_kind,
    output logic [ADDR_W-1:0] erase_target,
    input  logic              flash_done,
    input  logic              flash_fail,
    output logic              stat_busy,
    output logic              stat_err
);
    localparam int CHAIN_W = 2;
    localparam int START_POS = 0;

    logic [CHAIN_W-1:0] chain;
    logic               busy, err, launch;
    erase_kind_t        kind_sel, kind_q;
    logic [ADDR_W-1:0]  target_sel;

    erase_scan_chain #(.CHAIN_W(CHAIN_W)) u_chain (
        .clk(clk), .rst_n(rst_n),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .tdi(tdi),
        .busy(busy), .err(err), .tdo(tdo), .chain(chain)
    );

    erase_launch #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_launch (
        .update_dr(update_dr), .start_bit(chain[START_POS]), .busy(busy),
        .erase_mode(erase_mode), .flash_addr(flash_addr), .block_id(block_id),
        .launch(launch), .kind(kind_sel), .target(target_sel)
    );

    erase_status #(.ADDR_W(ADDR_W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .kind_in(kind_sel), .target_in(target_sel),
        .flash_done(flash_done), .flash_fail(flash_fail),
        .busy(busy), .err(err), .req(erase_req),
        .kind(kind_q), .target(erase_target)
    );

    assign erase_kind = kind_q;
    assign stat_busy  = busy;
    assign stat_err   = err;
endmodule

// File: rtl/flash_erase_tdr_checker.sv
// Port-level properties of the flash erase controller, bound to the top.
module flash_erase_tdr_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              capture_dr,
    input logic              shift_dr,
    input logic              update_dr,
    input logic              tdo,
    input logic [2:0]        erase_mode,
    input logic              erase_req,
    input logic [1:0]        erase_kind,
    input logic [ADDR_W-1:0] erase_target,
    input logic              flash_done,
    input logic              flash_fail,
    input logic              stat_busy,
    input logic              stat_err
);
    AST_REQ_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (stat_busy && !stat_err)); // R4
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req); // R4
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        stat_busy |=> !erase_req); // R8
    AST_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr |=> (tdo == $past(stat_busy))); // R2
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_busy && flash_done) |=> (!stat_busy && stat_err == $past(flash_fail))); // R9
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_busy && !update_dr) |=> ($stable(stat_busy) && $stable(stat_err))); // R11
    AST_MASS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && $past(erase_mode[2])) |-> (erase_kind == 2'd3 && erase_target == '0)); // R6
    AST_HOLD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_req |-> ($stable(erase_kind) && $stable(erase_target))); // R7
endmodule

bind flash_erase_tdr flash_erase_tdr_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdo(tdo), .erase_mode(erase_mode),
    .erase_req(erase_req), .erase_kind(erase_kind), .erase_target(erase_target),
    .flash_done(flash_done), .flash_fail(flash_fail),
    .stat_busy(stat_busy), .stat_err(stat_err)
);

// File: tb/flash_erase_tdr_tb.sv
// Sweeps Start x erase-mode x completion outcome on the erase controller.
module flash_erase_tdr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int BLK_W = 4;
    localparam int WATCHDOG = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo;
    logic [2:0] erase_mode = 0;
    logic [ADDR_W-1:0] flash_addr = 0;
    logic [BLK_W-1:0] block_id = 0;
    logic erase_req;
    logic [1:0] erase_kind;
    logic [ADDR_W-1:0] erase_target;
    logic flash_done = 0, flash_fail = 0;
    logic stat_busy, stat_err;

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_erase_tdr #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Capture, shift two bits (start first), update. Returns captured bits.
    // On return the edge after the update strobe has passed.
    task automatic scan(input logic start, input logic hi, output logic cap_busy, output logic cap_err);
        @(negedge clk) capture_dr = 1;
        @(negedge clk) capture_dr = 0; shift_dr = 1; tdi = start; cap_busy = tdo;
        @(negedge clk) tdi = hi; cap_err = tdo;
        @(negedge clk) shift_dr = 0; update_dr = 1;
        chk("R3 start bit at tdo", tdo, start);
        @(negedge clk) update_dr = 0;
    endtask

    function automatic logic [1:0] exp_kind(input logic [2:0] m);
        if (m[2]) return 2'd3;
        if (m[1]) return 2'd2;
        if (m[0]) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_target(input logic [2:0] m, input logic [ADDR_W-1:0] a, input logic [BLK_W-1:0] b);
        if (m[2]) return '0;
        if (m[1]) return ADDR_W'(b);
        return a;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic cb, ce;
        logic exp_err;
        logic [1:0] kind_now;
        logic [ADDR_W-1:0] tgt_now;
        repeat (3) @(negedge clk);
        chk("R1 busy", stat_busy, 0);
        chk("R1 err", stat_err, 0);
        chk("R1 req", erase_req, 0);
        chk("R1 tdo", tdo, 0);
        rst_n = 1;
        exp_err = 0;
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int m = 0; m < 8; m++) begin
                    logic go;
                    erase_mode = m[2:0];
                    flash_addr = ADDR_W'(16'h1230 + m * 16 + s * 4 + f);
                    block_id = BLK_W'(m + 5);
                    go = (s == 1) && (m != 0);
                    kind_now = erase_kind;
                    tgt_now = erase_target;
                    scan(s[0], 1'b1, cb, ce);
                    chk("R2 captured busy idle", cb, 0);
                    chk("R2 captured error", ce, exp_err);
                    if (go) begin
                        chk("R4 request", erase_req, 1);
                        chk("R4 busy", stat_busy, 1);
                        chk("R4 error cleared", stat_err, 0);
                        chk("R6 kind", erase_kind, exp_kind(m[2:0]));
                        chk("R7 target", erase_target, exp_target(m[2:0], flash_addr, block_id));
                        @(negedge clk);
                        chk("R4 request one cycle", erase_req, 0);
                        kind_now = erase_kind;
                        tgt_now = erase_target;
                        // R8: second start while busy, different mode.
                        erase_mode = ~m[2:0];
                        flash_addr = ~flash_addr;
                        scan(1'b1, 1'b0, cb, ce);
                        chk("R2 captured busy active", cb, 1);
                        chk("R8 no request", erase_req, 0);
                        chk("R8 kind held", erase_kind, kind_now);
                        chk("R8 target held", erase_target, tgt_now);
                        chk("R8 still busy", stat_busy, 1);
                        // R9: completion.
                        flash_fail = f[0]; flash_done = 1;
                        @(negedge clk) flash_done = 0; flash_fail = 0;
                        exp_err = f[0];
                        chk("R9 busy cleared", stat_busy, 0);
                        chk("R9 error", stat_err, exp_err);
                        chk("R10 mirror err via chain", stat_err, exp_err);
                    end else begin
                        chk("R5 no request", erase_req, 0);
                        chk("R5 busy unchanged", stat_busy, 0);
                        chk("R5 err unchanged", stat_err, exp_err);
                        chk("R7 kind held on no launch", erase_kind, kind_now);
                        chk("R7 target held on no launch", erase_target, tgt_now);
                    end
                    // R11: completion while idle is ignored.
                    flash_fail = ~exp_err; flash_done = 1;
                    @(negedge clk) flash_done = 0; flash_fail = 0;
                    chk("R11 busy", stat_busy, 0);
                    chk("R11 err", stat_err, exp_err);
                    // R10: status mirror matches what the chain captures.
                    scan(1'b0, 1'b0, cb, ce);
                    chk("R10 busy mirror", cb, stat_busy);
                    chk("R10 err mirror", ce, stat_err);
                end
            end
        end
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule